// File: doc/BRIEF.md
# Parallel Regex Payload Scanner

This block checks packet payloads against a small set of patterns that are fixed when the design is elaborated. Payload bytes arrive one per cycle on a byte-wide stream with a valid qualifier and start-of-packet and end-of-packet markers. Every pattern has its own automaton. All automata take in the same byte in the same cycle, so the cost per byte does not grow with the number of patterns.

A pattern is a sequence of tokens, each 10 bits wide, `{kind[1:0], char[7:0]}`. The token kinds are:

| Code | Kind | Matches |
|------|------|---------|
| 0 | literal | exactly the given byte |
| 1 | case-folded letter | either case of the given letter |
| 2 | single wildcard | any one byte |
| 3 | run wildcard | zero or more bytes of any value |

A pattern can match at any offset in the payload, and occurrences may overlap. Each pattern has a flag that stays set once its pattern has matched. The flags are cleared at the start of every packet. In the cycle after the end-of-packet byte, the whole flag vector is presented together with a one-cycle strobe.

The default pattern set has four patterns:

| Bit | Tokens |
|-----|--------|
| 0 | literal `a`, literal `a`, literal `b` |
| 1 | literal `x`, single wildcard, literal `z` |
| 2 | literal `g`, run wildcard, literal `k` |
| 3 | case-folded `h`, case-folded `i`, literal `!` |

Top module: `payload_scanner`

## Requirements
- R1: Every pattern automaton consumes the same accepted byte in the same cycle. A single packet can set several bits of `match_o`, with bit p belonging to pattern p.
- R2: A pattern matches wherever it occurs in the payload, including after unrelated leading bytes.
- R3: A literal token (kind 0) matches only its exact byte value and is case sensitive; `A` (0x41) does not match a literal `a` (0x61).
- R4: A single wildcard token (kind 2) consumes exactly one byte of any value, so pattern 1 matches `xqz` but not `xz` or `xqqz`.
- R5: A run wildcard token (kind 3) consumes zero or more bytes of any value, so pattern 2 matches both `gk` and `g12k`.
- R6: A case-folded token (kind 1) matches the letter in either upper or lower case.
- R7: After a partial match fails, the automaton keeps the longest prefix that is still consistent, so `aaab` matches pattern 0.
- R8: A byte marked start-of-packet is evaluated from the idle state, and the flags begin empty. Neither partial progress nor flags carry from one packet into the next.
- R9: Once a pattern's flag is set, it stays set until the packet's end-of-packet byte, whatever bytes follow.
- R10: While `valid_i` is low, every automaton holds its state and `data_i` is ignored. A pattern split by idle cycles still matches, and a byte shown during an idle cycle never counts toward a match.
- R11: In the cycle after the accepted end-of-packet byte, `done_o` is high for exactly one cycle and `match_o` carries the packet's flags, including any match on the last byte. `match_o` then holds its value until the next strobe.
- R12: After reset, `done_o` and `match_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Byte on `data_i` is accepted this cycle |
| data_i | input | 8 | Payload byte |
| sop_i | input | 1 | Accepted byte is the first byte of a packet |
| eop_i | input | 1 | Accepted byte is the last byte of a packet |
| match_o | output | NUM_PAT | Per-pattern match flags of the last finished packet |
| done_o | output | 1 | One-cycle strobe: `match_o` was just updated |

## Verification
The assertions check the rules that hold on every cycle:

- An automaton's state does not change while the input is idle.
- The strobe follows exactly the accepted end-of-packet bytes and no other cycle.
- Flags are never lost in the middle of a packet.
- Flags are empty after an end of packet.
- `match_o` changes only with the strobe.

Only the bench's scenarios can show that the automata recognise the right language:

- literal case sensitivity;
- the exact one-byte width of the single wildcard;
- the zero-length and long runs of the run wildcard;
- case folding;
- fallback on overlapping text;
- isolation between consecutive packets.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int TOK_W   = 10;
  localparam int DEF_NUM = 4;
  localparam int DEF_MAX = 8;

  typedef enum logic [1:0] {
    TK_LIT    = 2'd0,
    TK_NOCASE = 2'd1,
    TK_ONE    = 2'd2,
    TK_MANY   = 2'd3
  } tok_kind_e;

  function automatic logic [TOK_W-1:0] mk_tok(tok_kind_e k, logic [7:0] c);
    return {k, c};
  endfunction

  function automatic logic [7:0] fold(logic [7:0] c);
    if (c >= 8'h41 && c <= 8'h5a) return c | 8'h20;
    return c;
  endfunction

  function automatic logic tok_hit(logic [TOK_W-1:0] t, logic [7:0] b);
    case (tok_kind_e'(t[TOK_W-1 -: 2]))
      TK_LIT:    return b == t[7:0];
      TK_NOCASE: return fold(b) == fold(t[7:0]);
      default:   return 1'b1;
    endcase
  endfunction

  function automatic logic [DEF_NUM*DEF_MAX*TOK_W-1:0] def_tokens();
    logic [DEF_NUM*DEF_MAX*TOK_W-1:0] t;
    t = '0;
    // pattern 0: "aab"
    t[(0*DEF_MAX+0)*TOK_W +: TOK_W] = mk_tok(TK_LIT, 8'h61);
    t[(0*DEF_MAX+1)*TOK_W +: TOK_W] = mk_tok(TK_LIT, 8'h61);
    t[(0*DEF_MAX+2)*TOK_W +: TOK_W] = mk_tok(TK_LIT, 8'h62);
    // pattern 1: "x?z"
    t[(1*DEF_MAX+0)*TOK_W +: TOK_W] = mk_tok(TK_LIT, 8'h78);
    t[(1*DEF_MAX+1)*TOK_W +: TOK_W] = mk_tok(TK_ONE, 8'h00);
    t[(1*DEF_MAX+2)*TOK_W +: TOK_W] = mk_tok(TK_LIT, 8'h7a);
    // pattern 2: "g*k"
    t[(2*DEF_MAX+0)*TOK_W +: TOK_W] = mk_tok(TK_LIT, 8'h67);
    t[(2*DEF_MAX+1)*TOK_W +: TOK_W] = mk_tok(TK_MANY, 8'h00);
    t[(2*DEF_MAX+2)*TOK_W +: TOK_W] = mk_tok(TK_LIT, 8'h6b);
    // pattern 3: [hH][iI]"!"
    t[(3*DEF_MAX+0)*TOK_W +: TOK_W] = mk_tok(TK_NOCASE, 8'h68);
    t[(3*DEF_MAX+1)*TOK_W +: TOK_W] = mk_tok(TK_NOCASE, 8'h69);
    t[(3*DEF_MAX+2)*TOK_W +: TOK_W] = mk_tok(TK_LIT, 8'h21);
    return t;
  endfunction

  function automatic logic [DEF_NUM*8-1:0] def_lens();
    return {8'd3, 8'd3, 8'd3, 8'd3};
  endfunction
endpackage

// File: rtl/scan_dfa.sv
module scan_dfa
  import scan_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int LEN     = 3,
  parameter logic [MAX_LEN*TOK_W-1:0] TOKS = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sop_i,
  input  logic [7:0] data_i,
  output logic       hit_o
);
  localparam int SW = MAX_LEN + 1;

  // state bit i: first i tokens are matched ending at the last byte
  logic [SW-1:0] state_q, state_d, base, nxt, closed;
  logic [TOK_W-1:0] tk;

  // a run wildcard may match zero bytes: propagate across it
  function automatic logic [SW-1:0] closure(logic [SW-1:0] v);
    logic [SW-1:0] r;
    r = v;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (i < LEN && TOKS[i*TOK_W+8 +: 2] == 2'(TK_MANY)) r[i+1] = r[i+1] | r[i];
    end
    return r;
  endfunction

  always_comb begin
    tk   = '0;
    base = closure(sop_i ? SW'(1) : state_q);
    nxt  = '0;
    nxt[0] = 1'b1;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (i < LEN) begin
        tk = TOKS[i*TOK_W +: TOK_W];
        if (tk[TOK_W-1 -: 2] == 2'(TK_MANY)) nxt[i+1] = base[i] | base[i+1];
        else                                  nxt[i+1] = base[i] & tok_hit(tk, data_i);
      end
    end
    closed  = closure(nxt);
    state_d = valid_i ? closed : state_q;
    hit_o   = valid_i & closed[LEN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SW'(1);
    else         state_q <= state_d;
  end

  AST_FROZEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q)); // R10
endmodule

// File: rtl/scan_collect.sv
module scan_collect #(
  parameter int NUM_PAT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               sop_i,
  input  logic               eop_i,
  input  logic [NUM_PAT-1:0] hit_i,
  output logic [NUM_PAT-1:0] match_o,
  output logic               done_o
);
  logic [NUM_PAT-1:0] flags_q, flags_cur;

  assign flags_cur = (sop_i ? '0 : flags_q) | hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      match_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= valid_i & eop_i;
      if (valid_i) begin
        if (eop_i) begin
          flags_q <= '0;
          match_o <= flags_cur;
        end else begin
          flags_q <= flags_cur;
        end
      end
    end
  end

  AST_STROBE_AFTER_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eop_i) |=> done_o); // R11
  AST_NO_STRAY_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && eop_i) |=> !done_o); // R11
  AST_MATCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(match_o)); // R11
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (sop_i || eop_i)) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R9
  AST_EOP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eop_i) |=> (flags_q == '0)); // R8
endmodule

// File: rtl/payload_scanner.sv
module payload_scanner
  import scan_pkg::*;
#(
  parameter int NUM_PAT = DEF_NUM,
  parameter int MAX_LEN = DEF_MAX,
  parameter logic [NUM_PAT*MAX_LEN*TOK_W-1:0] PAT_TOKS = def_tokens(),
  parameter logic [NUM_PAT*8-1:0]             PAT_LENS = def_lens()
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [7:0]         data_i,
  input  logic               sop_i,
  input  logic               eop_i,
  output logic [NUM_PAT-1:0] match_o,
  output logic               done_o
);
  localparam int PAT_W = MAX_LEN * TOK_W;

  logic [NUM_PAT-1:0] hit;

  // R1: one automaton per pattern, all fed the same byte
  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    scan_dfa #(
      .MAX_LEN (MAX_LEN),
      .LEN     (int'(PAT_LENS[p*8 +: 8])),
      .TOKS    (PAT_TOKS[p*PAT_W +: PAT_W])
    ) u_dfa (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .sop_i   (sop_i),
      .data_i  (data_i),
      .hit_o   (hit[p])
    );
  end

  scan_collect #(.NUM_PAT(NUM_PAT)) u_collect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sop_i   (sop_i),
    .eop_i   (eop_i),
    .hit_i   (hit),
    .match_o (match_o),
    .done_o  (done_o)
  );

  AST_HIT_ONLY_ON_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |-> valid_i); // R10
endmodule

// File: tb/tb_payload_scanner.sv
module tb_payload_scanner;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       sop_i = 1'b0;
  logic       eop_i = 1'b0;
  logic [3:0] match_o;
  logic       done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  payload_scanner dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .sop_i(sop_i), .eop_i(eop_i), .match_o(match_o), .done_o(done_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // send one packet; optionally an idle cycle carrying gap_data after each non-final byte
  task automatic run_pkt(input string s, input logic [3:0] exp, input string tag,
                         input bit gaps, input logic [7:0] gap_data);
    for (int i = 0; i < s.len(); i++) begin
      valid_i = 1'b1;
      data_i  = s[i];
      sop_i   = (i == 0);
      eop_i   = (i == s.len() - 1);
      @(negedge clk);
      if (gaps && i != s.len() - 1) begin
        valid_i = 1'b0; data_i = gap_data; sop_i = 1'b1; eop_i = 1'b1;
        @(negedge clk);
      end
    end
    valid_i = 1'b0; sop_i = 1'b0; eop_i = 1'b0; data_i = 8'h00;
    check(32'(done_o), 32'd1, {tag, " R11 strobe"});
    check(32'(match_o), 32'(exp), {tag, " match \"", s, "\""});
    @(negedge clk);
    check(32'(done_o), 32'd0, {tag, " R11 strobe one cycle"});
    check(32'(match_o), 32'(exp), {tag, " R11 match held"});
  endtask

  task automatic t_reset();
    check(32'(done_o), 32'd0, "R12 done in reset");
    check(32'(match_o), 32'd0, "R12 match in reset");
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    check(32'(done_o), 32'd0, "R12 done after reset");
    check(32'(match_o), 32'd0, "R12 match after reset");
  endtask

  task automatic t_literal();
    run_pkt("zzaabzz", 4'b0001, "R2", 1'b0, 8'h0);
    run_pkt("AAB", 4'b0000, "R3", 1'b0, 8'h0);
    run_pkt("aAb", 4'b0000, "R3", 1'b0, 8'h0);
  endtask

  task automatic t_single_wild();
    run_pkt("xqz", 4'b0010, "R4", 1'b0, 8'h0);
    run_pkt("xz", 4'b0000, "R4", 1'b0, 8'h0);
    run_pkt("xqqz", 4'b0000, "R4", 1'b0, 8'h0);
  endtask

  task automatic t_run_wild();
    run_pkt("gk", 4'b0100, "R5", 1'b0, 8'h0);
    run_pkt("g12k", 4'b0100, "R5", 1'b0, 8'h0);
    run_pkt("kg", 4'b0000, "R5", 1'b0, 8'h0);
  endtask

  task automatic t_case();
    run_pkt("HI!", 4'b1000, "R6", 1'b0, 8'h0);
    run_pkt("hI!", 4'b1000, "R6", 1'b0, 8'h0);
    run_pkt("hi?", 4'b0000, "R6", 1'b0, 8'h0);
  endtask

  task automatic t_overlap();
    run_pkt("aaab", 4'b0001, "R7", 1'b0, 8'h0);
    run_pkt("aaaaab", 4'b0001, "R7", 1'b0, 8'h0);
  endtask

  task automatic t_parallel();
    run_pkt("aabxyzhi!gk", 4'b1111, "R1", 1'b0, 8'h0);
  endtask

  task automatic t_sticky();
    run_pkt("aabqqqqq", 4'b0001, "R9", 1'b0, 8'h0);
  endtask

  task automatic t_isolation();
    run_pkt("a", 4'b0000, "R8 first", 1'b0, 8'h0);
    run_pkt("ab", 4'b0000, "R8 no carry of state", 1'b0, 8'h0);
    run_pkt("aab", 4'b0001, "R8 set", 1'b0, 8'h0);
    run_pkt("q", 4'b0000, "R8 no carry of flags", 1'b0, 8'h0);
  endtask

  task automatic t_gaps();
    run_pkt("aab", 4'b0001, "R10 split", 1'b1, 8'h7a);
    run_pkt("xz", 4'b0000, "R10 idle byte ignored", 1'b1, 8'h71);
    run_pkt("HI!", 4'b1000, "R10 split case", 1'b1, 8'h78);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_literal();
    t_single_wild();
    t_run_wild();
    t_case();
    t_overlap();
    t_parallel();
    t_sticky();
    t_isolation();
    t_gaps();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule